// File: doc/BRIEF.md
# Potentiometer Command Sequencer

This block sits behind a byte-level serial front end and carries out the commands for a bank of four digital potentiometer channels. The front end reports each start condition, each stop condition and each completed byte. The block tells it whether to acknowledge, supplies the byte to send back for reads, and reports when a modelled nonvolatile write is in progress. Each channel holds a volatile 8-bit wiper counter and four 8-bit data registers that model nonvolatile storage. The counter drives the channel's wiper code.

A transaction opens with an address byte. Its upper nibble is the fixed type code `0101` and its lower nibble must equal `dev_addr_i`. An instruction byte follows, and for some commands a data byte follows that. Writes take effect only at the stop condition. A change to any data register holds the block busy for `NV_CYCLES` clock cycles, and address bytes are refused while it is busy, so a host can poll for completion. A load into a wiper counter from a write or a transfer lands `WIPER_DLY` cycles after the stop. In increment/decrement mode the front end passes single up or down steps for the selected wiper.

Top module: `potcmd_seq`

## Requirements
- R1: After reset, each wiper counter i equals byte i of `INIT_DR0`, which is also the reset content of data register 0 of channel i. Data registers 1 to 3 reset to 0. `busy_o`, `ack_o` and `incdec_o` are low. `wiper_o[8i+7:8i]` carries counter i.
- R2: The first byte after a start is acknowledged (`ack_o` high from the cycle after the byte) only if it equals `{4'b0101, dev_addr_i}` and the block is not busy. Otherwise it is refused, and every later byte is refused and ignored until the next start.
- R3: The instruction byte holds the opcode in bits 7:4, the channel in bits 3:2 and the register in bits 1:0. The opcodes are 9 read counter, A write counter, B read data register, C write data register, D data register to counter, E counter to data register, 1 global data register to counter, 8 global counter to data register, and 2 increment/decrement. A known opcode is acknowledged. Any other opcode is refused, and the transaction changes no state.
- R4: Write counter is a three-byte sequence with an acknowledged data byte. The selected wiper takes the data byte exactly `WIPER_DLY` cycles after the clock edge that samples the stop.
- R5: Read counter and read data register place the selected value on `rd_data_o` in the cycle after the instruction byte. The byte that follows is not acknowledged, and the read changes no state.
- R6: Write data register stores the data byte at the stop. `busy_o` is high for exactly `NV_CYCLES` cycles, starting in the cycle after the stop is sampled.
- R7: Data register to counter (two bytes) loads the selected counter from its selected data register `WIPER_DLY` cycles after the stop, and it does not raise `busy_o`.
- R8: Counter to data register (two bytes) stores the selected counter into the selected data register of the same channel at the stop, and it raises `busy_o` as in R6.
- R9: Global data register to counter loads every counter from its own data register chosen by bits 1:0, `WIPER_DLY` cycles after the stop. The channel bits are ignored.
- R10: Global counter to data register stores every counter into its own data register chosen by bits 1:0 at the stop, and it raises `busy_o`.
- R11: A write or transfer is committed only if the stop directly follows the acknowledged final byte of its sequence. A new start, or any extra byte, before the stop cancels it.
- R12: While `busy_o` is high, an address byte is refused. Once busy ends, the same address byte is acknowledged.
- R13: After an acknowledged opcode 2, `incdec_o` is high. Each `step_i` pulse moves bits 5:0 of the selected counter by one, up when `step_up_i` is 1, saturating at 0 and 63, and it keeps bits 7:6. A stop or start ends the mode. Steps outside the mode are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dev_addr_i | input | 4 | Strapped device address, low nibble of the address byte |
| start_i | input | 1 | One-cycle pulse: start condition seen |
| stop_i | input | 1 | One-cycle pulse: stop condition seen |
| byte_vld_i | input | 1 | One-cycle pulse: a byte has completed |
| byte_i | input | 8 | Byte received, valid with `byte_vld_i` |
| step_i | input | 1 | One-cycle pulse: one increment/decrement step |
| step_up_i | input | 1 | Step direction, 1 toward the top end |
| ack_o | output | 1 | Acknowledge decision for the last byte |
| rd_data_o | output | 8 | Byte to transmit for read commands |
| busy_o | output | 1 | Modelled nonvolatile write in progress |
| incdec_o | output | 1 | Increment/decrement mode active |
| wiper_o | output | 32 | Four wiper counters, channel i in bits 8i+7:8i |

## Verification
A wrong transaction state shows up within one byte as a wrong `ack_o` value, because every byte's acknowledge depends on the phase and the decoded opcode. A corrupt data register stays hidden until a read or transfer brings it out, so the bench reads back or transfers each register it writes. Counter errors appear on `wiper_o` exactly `WIPER_DLY` cycles after a stop, and busy errors appear as a wrong edge on `busy_o` `NV_CYCLES` cycles after the stop. The bench samples both edges on the exact cycle.

// File: rtl/potcmd_seq.sv
module potcmd_seq #(
  parameter int unsigned NV_CYCLES = 500000,
  parameter int unsigned WIPER_DLY = 25,
  parameter logic [31:0] INIT_DR0  = 32'h2020_2020
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [3:0]  dev_addr_i,
  input  logic        start_i,
  input  logic        stop_i,
  input  logic        byte_vld_i,
  input  logic [7:0]  byte_i,
  input  logic        step_i,
  input  logic        step_up_i,
  output logic        ack_o,
  output logic [7:0]  rd_data_o,
  output logic        busy_o,
  output logic        incdec_o,
  output logic [31:0] wiper_o
);

  localparam int unsigned NCH  = 4;
  localparam int unsigned NREG = 4;
  localparam int unsigned CW   = $clog2(NV_CYCLES + 1);
  localparam int unsigned DW   = $clog2(WIPER_DLY + 2);

  localparam logic [3:0] OP_RDW  = 4'h9;
  localparam logic [3:0] OP_WRW  = 4'hA;
  localparam logic [3:0] OP_RDD  = 4'hB;
  localparam logic [3:0] OP_WRD  = 4'hC;
  localparam logic [3:0] OP_D2W  = 4'hD;
  localparam logic [3:0] OP_W2D  = 4'hE;
  localparam logic [3:0] OP_GD2W = 4'h1;
  localparam logic [3:0] OP_GW2D = 4'h8;
  localparam logic [3:0] OP_STEP = 4'h2;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_INSTR, S_DATA, S_TAIL, S_STEP, S_SKIP} st_t;

  st_t             st_q;
  logic [3:0]      op_q;
  logic [1:0]      pot_q, reg_q;
  logic [7:0]      data_q, rd_q;
  logic            pend_q, ack_q;
  logic [7:0]      wcr_q   [NCH];
  logic [7:0]      dr_q    [NCH][NREG];
  logic [7:0]      apply_q [NCH];
  logic [NCH-1:0]  mask_q;
  logic [CW-1:0]   nv_cnt_q;
  logic [DW-1:0]   wd_cnt_q;

  function automatic logic op_known(input logic [3:0] op);
    case (op)
      OP_RDW, OP_WRW, OP_RDD, OP_WRD, OP_D2W,
      OP_W2D, OP_GD2W, OP_GW2D, OP_STEP: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] nudge(input logic [7:0] v, input logic up);
    logic [5:0] t;
    t = v[5:0];
    if (up && t != 6'h3F) t = t + 6'd1;
    else if (!up && t != 6'h00) t = t - 6'd1;
    return {v[7:6], t};
  endfunction

  logic addr_hit, is_read, commit;
  assign addr_hit = (byte_i == {4'b0101, dev_addr_i});
  assign is_read  = (op_q == OP_RDW) || (op_q == OP_RDD);
  assign commit   = stop_i && !start_i && (st_q == S_TAIL) && pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      op_q     <= '0;
      pot_q    <= '0;
      reg_q    <= '0;
      data_q   <= '0;
      rd_q     <= '0;
      pend_q   <= 1'b0;
      ack_q    <= 1'b0;
      mask_q   <= '0;
      nv_cnt_q <= '0;
      wd_cnt_q <= '0;
      for (int i = 0; i < NCH; i++) begin
        wcr_q[i]   <= INIT_DR0[8*i +: 8];
        apply_q[i] <= '0;
        for (int j = 0; j < NREG; j++)
          dr_q[i][j] <= (j == 0) ? INIT_DR0[8*i +: 8] : 8'h00;
      end
    end else begin
      if (nv_cnt_q != '0) nv_cnt_q <= nv_cnt_q - 1'b1;
      if (wd_cnt_q != '0) wd_cnt_q <= wd_cnt_q - 1'b1;
      if (wd_cnt_q == DW'(1))
        for (int i = 0; i < NCH; i++)
          if (mask_q[i]) wcr_q[i] <= apply_q[i];

      if (start_i) begin
        st_q   <= S_ADDR;
        pend_q <= 1'b0;
        ack_q  <= 1'b0;
      end else if (stop_i) begin
        st_q   <= S_IDLE;
        pend_q <= 1'b0;
        ack_q  <= 1'b0;
        if (commit) begin
          case (op_q)
            OP_WRW: begin
              mask_q          <= NCH'(1) << pot_q;
              apply_q[pot_q]  <= data_q;
              wd_cnt_q        <= DW'(WIPER_DLY);
            end
            OP_D2W: begin
              mask_q          <= NCH'(1) << pot_q;
              apply_q[pot_q]  <= dr_q[pot_q][reg_q];
              wd_cnt_q        <= DW'(WIPER_DLY);
            end
            OP_GD2W: begin
              mask_q <= '1;
              for (int i = 0; i < NCH; i++) apply_q[i] <= dr_q[i][reg_q];
              wd_cnt_q <= DW'(WIPER_DLY);
            end
            OP_WRD: begin
              dr_q[pot_q][reg_q] <= data_q;
              nv_cnt_q           <= CW'(NV_CYCLES);
            end
            OP_W2D: begin
              dr_q[pot_q][reg_q] <= wcr_q[pot_q];
              nv_cnt_q           <= CW'(NV_CYCLES);
            end
            OP_GW2D: begin
              for (int i = 0; i < NCH; i++) dr_q[i][reg_q] <= wcr_q[i];
              nv_cnt_q <= CW'(NV_CYCLES);
            end
            default: ;
          endcase
        end
      end else if (byte_vld_i) begin
        case (st_q)
          S_ADDR: begin
            ack_q <= addr_hit && (nv_cnt_q == '0);
            st_q  <= (addr_hit && (nv_cnt_q == '0)) ? S_INSTR : S_SKIP;
          end
          S_INSTR: begin
            op_q  <= byte_i[7:4];
            pot_q <= byte_i[3:2];
            reg_q <= byte_i[1:0];
            ack_q <= op_known(byte_i[7:4]);
            case (byte_i[7:4])
              OP_RDW: begin rd_q <= wcr_q[byte_i[3:2]]; st_q <= S_DATA; end
              OP_RDD: begin rd_q <= dr_q[byte_i[3:2]][byte_i[1:0]]; st_q <= S_DATA; end
              OP_WRW, OP_WRD: st_q <= S_DATA;
              OP_D2W, OP_W2D, OP_GD2W, OP_GW2D: begin st_q <= S_TAIL; pend_q <= 1'b1; end
              OP_STEP: st_q <= S_STEP;
              default: st_q <= S_SKIP;
            endcase
          end
          S_DATA: begin
            st_q <= S_TAIL;
            if (is_read) begin
              ack_q  <= 1'b0;
              pend_q <= 1'b0;
            end else begin
              ack_q  <= 1'b1;
              data_q <= byte_i;
              pend_q <= 1'b1;
            end
          end
          S_IDLE: ack_q <= 1'b0;
          default: begin
            ack_q  <= 1'b0;
            pend_q <= 1'b0;
            st_q   <= S_SKIP;
          end
        endcase
      end

      if (st_q == S_STEP && step_i && !start_i && !stop_i)
        wcr_q[pot_q] <= nudge(wcr_q[pot_q], step_up_i);
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_wiper
    assign wiper_o[8*g +: 8] = wcr_q[g];
  end

  assign ack_o     = ack_q;
  assign rd_data_o = rd_q;
  assign busy_o    = (nv_cnt_q != '0);
  assign incdec_o  = (st_q == S_STEP);

endmodule

module potcmd_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       stop_i,
  input logic       byte_vld_i,
  input logic [7:0] byte_i,
  input logic       ack_o,
  input logic       busy_o,
  input logic       incdec_o
);
  logic addr_phase_q;
  logic addr_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         addr_phase_q <= 1'b0;
    else if (start_i)    addr_phase_q <= 1'b1;
    else if (stop_i || byte_vld_i) addr_phase_q <= 1'b0;
  end

  assign addr_byte = addr_phase_q && byte_vld_i && !start_i && !stop_i;

  p_ack_needs_byte_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(byte_vld_i));

  p_type_nack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_byte && byte_i[7:4] != 4'b0101 |=> !ack_o);

  p_busy_nack_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_byte && busy_o |=> !ack_o);

  p_busy_from_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i));

  p_step_exit_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i || start_i) |=> !incdec_o);

  p_edge_clears_ack_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i || start_i) |=> !ack_o);
endmodule

bind potcmd_seq potcmd_seq_chk i_potcmd_seq_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
  .byte_vld_i(byte_vld_i), .byte_i(byte_i), .ack_o(ack_o),
  .busy_o(busy_o), .incdec_o(incdec_o)
);

// File: tb/test_potcmd_seq.sv
module test_potcmd_seq;
  localparam int unsigned NV = 40;
  localparam int unsigned WD = 3;
  localparam logic [31:0] INIT = 32'h3F2A_1500;
  localparam logic [7:0]  ADR  = 8'h5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  dev_addr = 4'hA;
  logic        start_i = 0, stop_i = 0, byte_vld = 0, step_i = 0, step_up = 0;
  logic [7:0]  byte_d = 8'h00;
  logic        ack, busy, incdec;
  logic [7:0]  rd_data;
  logic [31:0] wiper;
  int          nchk = 0, nfail = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  potcmd_seq #(.NV_CYCLES(NV), .WIPER_DLY(WD), .INIT_DR0(INIT)) i_potcmd_seq (
    .clk_i(clk), .rst_ni(rst_n), .dev_addr_i(dev_addr), .start_i(start_i),
    .stop_i(stop_i), .byte_vld_i(byte_vld), .byte_i(byte_d), .step_i(step_i),
    .step_up_i(step_up), .ack_o(ack), .rd_data_o(rd_data), .busy_o(busy),
    .incdec_o(incdec), .wiper_o(wiper));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic p_start();
    @(negedge clk) start_i = 1; @(negedge clk) start_i = 0;
  endtask
  task automatic p_stop();
    @(negedge clk) stop_i = 1; @(negedge clk) stop_i = 0;
  endtask
  task automatic p_byte(input logic [7:0] b);
    @(negedge clk) begin byte_vld = 1; byte_d = b; end
    @(negedge clk) byte_vld = 0;
  endtask
  task automatic p_step(input logic up);
    @(negedge clk) begin step_i = 1; step_up = up; end
    @(negedge clk) step_i = 0;
  endtask

  task automatic head(input logic [7:0] ins, input string req);
    p_start(); p_byte(ADR); chk({req, " addr ack"}, ack, 1);
    p_byte(ins); chk({req, " instr ack"}, ack, 1);
  endtask

  task automatic cmd3(input logic [7:0] ins, input logic [7:0] d, input string req);
    head(ins, req); p_byte(d); chk({req, " data ack"}, ack, 1); p_stop();
  endtask

  task automatic cmd2(input logic [7:0] ins, input string req);
    head(ins, req); p_stop();
  endtask

  task automatic rd(input logic [7:0] ins, input logic [7:0] exp, input string req);
    head(ins, req); chk({req, " read value"}, rd_data, exp);
    p_byte(8'hFF); chk({req, " read byte not acked"}, ack, 0); p_stop();
  endtask

  task automatic t_reset();
    chk("R1 wiper reset", wiper, INIT);
    chk("R1 busy reset", busy, 0);
    chk("R1 ack reset", ack, 0);
    chk("R1 incdec reset", incdec, 0);
    rd(8'hB6, 8'h00, "R1 dr1 reg2 reset");
  endtask

  task automatic t_write_wcr();
    cmd3(8'hA4, 8'h33, "R4 write counter ch1");
    chk("R4 no busy", busy, 0);
    cyc(WD - 1); chk("R4 before delay", wiper, 32'h3F2A_1500);
    cyc(1);      chk("R4 after delay", wiper, 32'h3F2A_3300);
    rd(8'h94, 8'h33, "R5 read counter ch1");
  endtask

  task automatic t_write_dr();
    cmd3(8'hCB, 8'h5C, "R6 write dr ch2 reg3");
    chk("R6 busy first cycle", busy, 1);
    cyc(NV - 1); chk("R6 busy last cycle", busy, 1);
    cyc(1);      chk("R6 busy cleared", busy, 0);
    rd(8'hBB, 8'h5C, "R6 read back dr ch2 reg3");
    chk("R5 read no side effect", wiper, 32'h3F2A_3300);
  endtask

  task automatic t_xfer();
    cmd2(8'hDB, "R7 dr to counter ch2");
    chk("R7 no busy", busy, 0);
    cyc(WD - 1); chk("R7 before delay", wiper, 32'h3F2A_3300);
    cyc(1);      chk("R7 after delay", wiper, 32'h3F5C_3300);
    cmd2(8'hE6, "R8 counter to dr ch1 reg2");
    chk("R8 busy", busy, 1);
    p_start(); p_byte(ADR); chk("R12 address refused while busy", ack, 0);
    p_byte(8'h94); chk("R12 later byte refused", ack, 0); p_stop();
    cyc(NV);
    chk("R12 busy ended", busy, 0);
    rd(8'hB6, 8'h33, "R8 R12 read dr ch1 reg2");
  endtask

  task automatic t_global();
    cmd2(8'h81, "R10 global counter to dr reg1");
    chk("R10 busy", busy, 1);
    cyc(NV + 1);
    cmd3(8'hA0, 8'h11, "R4 write counter ch0");
    cyc(WD + 1);
    chk("R4 ch0 written", wiper, 32'h3F5C_3311);
    cmd2(8'h1D, "R9 global dr reg1 to counter");
    chk("R9 no busy", busy, 0);
    cyc(WD - 1); chk("R9 before delay", wiper, 32'h3F5C_3311);
    cyc(1);      chk("R9 after delay", wiper, 32'h3F5C_3300);
    rd(8'hBD, 8'h3F, "R10 dr ch3 reg1");
    rd(8'hB9, 8'h5C, "R10 dr ch2 reg1");
  endtask

  task automatic t_abort();
    head(8'hAC, "R11 start abort"); p_byte(8'h01); chk("R11 data ack", ack, 1);
    p_start(); p_stop(); cyc(WD + 2);
    chk("R11 start cancels write", wiper, 32'h3F5C_3300);
    head(8'hAC, "R11 extra byte"); p_byte(8'h01); p_byte(8'h77);
    chk("R11 extra byte refused", ack, 0); p_stop(); cyc(WD + 2);
    chk("R11 extra byte cancels write", wiper, 32'h3F5C_3300);
    head(8'hC0, "R11 dr abort"); p_byte(8'h99); p_start(); p_stop();
    chk("R11 cancelled dr write no busy", busy, 0);
    rd(8'hB0, 8'h00, "R11 dr ch0 reg0 unchanged");
    head(8'hD4, "R11 two-byte extra"); p_byte(8'h00); p_stop(); cyc(WD + 2);
    chk("R11 transfer cancelled", wiper, 32'h3F5C_3300);
    cmd2(8'hD4, "R7 dr ch1 reg0 to counter"); cyc(WD);
    chk("R7 ch1 from reg0", wiper, 32'h3F5C_1500);
  endtask

  task automatic t_bad();
    p_start(); p_byte(8'h5B); chk("R2 wrong device refused", ack, 0);
    p_byte(8'hA4); chk("R2 following byte refused", ack, 0);
    p_byte(8'h44); p_stop(); cyc(WD + 2);
    chk("R2 no change", wiper, 32'h3F5C_1500);
    p_start(); p_byte(8'h4A); chk("R2 wrong type refused", ack, 0); p_stop();
    p_start(); p_byte(ADR); p_byte(8'h34); chk("R3 opcode 3 refused", ack, 0);
    p_byte(8'h77); chk("R3 later byte refused", ack, 0); p_stop(); cyc(WD + 2);
    chk("R3 no change", wiper, 32'h3F5C_1500);
    chk("R3 no busy", busy, 0);
    p_start(); p_byte(ADR); p_byte(8'hF0); chk("R3 opcode F refused", ack, 0); p_stop();
  endtask

  task automatic t_step();
    p_step(1); chk("R13 step outside mode", wiper, 32'h3F5C_1500);
    head(8'h20, "R13 enter ch0"); chk("R13 mode flag", incdec, 1);
    p_step(0); chk("R13 saturate low", wiper[7:0], 8'h00);
    p_step(1); p_step(1); p_step(1); chk("R13 three up", wiper[7:0], 8'h03);
    p_stop(); chk("R13 stop exits", incdec, 0);
    p_step(1); chk("R13 step after stop", wiper[7:0], 8'h03);
    head(8'h2C, "R13 enter ch3");
    p_step(1); chk("R13 saturate high", wiper[31:24], 8'h3F);
    p_step(0); chk("R13 down", wiper[31:24], 8'h3E);
    p_stop();
    cmd3(8'hA8, 8'hC5, "R13 preset ch2"); cyc(WD);
    head(8'h28, "R13 enter ch2");
    p_step(1); chk("R13 top bits kept", wiper[23:16], 8'hC6);
    p_stop();
    chk("R13 other channels", wiper, 32'h3EC6_1503);
  endtask

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    t_reset();
    t_write_wcr();
    t_write_dr();
    t_xfer();
    t_global();
    t_abort();
    t_bad();
    t_step();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule